// File: doc/BRIEF.md
# Read Data Capture Window Controller

This block runs next to a DDR command sequencer during read bursts. The sequencer pulses one input when it issues the first READ command of a transaction and another when it issues the last one. Along with the first pulse it presents the number of READ commands in the burst and the programmed CAS latency. The controller waits that latency, then opens the enable that lets the read data and strobe capture path take data. It counts the returning data pairs, where one pair is the two words from one READ command. When the last expected pair has been accepted, it closes the window and pulses a release output one cycle later. That pulse tells the sequencer to negate chip select and start a new transaction.

The window has a hard ceiling measured from the last READ command. If pairs are still missing when the ceiling is reached, the window closes anyway, the release pulse is still produced, and a sticky timeout flag is set. The flag reports a read data loop that is too slow for the board.

Returning pairs arrive on a valid-only strobe. The capture path samples data at a fixed time and cannot be stalled, so there is no ready signal and no back-pressure. A pair offered while the window is closed is dropped and is not counted. Command pulses, latency and count are plain control inputs.

Top module: `rdw_capture_ctrl`

## Requirements
- R1: A synchronous active-high reset closes the window and clears the transaction, the pair count and the timeout flag. While reset is held and in the first cycle after it, `cap_en`, `cs_release`, `busy` and `timeout` are all 0.
- R2: `rd_first` sampled while `busy` is 0 starts a transaction. `busy` is 1 from the next cycle. `rd_cmds` and `cas_lat` are latched at that edge, so later changes on those inputs have no effect. Only `cas_lat` values 2 and 3 are supported, and `rd_cmds` must be at least 1.
- R3: `cap_en` first goes high exactly `cas_lat` cycles after the cycle in which the starting `rd_first` was high.
- R4: A `pair_valid` in a cycle where `cap_en` is 1 counts one returned pair. A `pair_valid` while `cap_en` is 0 is ignored and does not change when the transaction ends.
- R5: In the cycle after the pair that brings the count to `rd_cmds`, `cap_en` and `busy` are 0 and `cs_release` is 1 for exactly one cycle. A `rd_first` in that same cycle starts a new transaction.
- R6: Let L be the cycle in which `rd_last` is high. `cap_en` is never 1 after cycle L+CL+1. If pairs are still missing at that point, then in cycle L+CL+2 `cap_en` and `busy` are 0, `cs_release` pulses and `timeout` becomes 1.
- R7: `timeout` stays 1 until reset, including through later transactions that complete normally.
- R8: `rd_first` while `busy` is 1 is ignored.
- R9: A final pair accepted in cycle L+CL+1, the last open cycle, completes normally and does not set `timeout`.
- R10: `rd_last` may be high in the same cycle as the starting `rd_first`, which gives a single-READ transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_first | input | 1 | Pulse when the first READ command of a burst is issued |
| rd_last | input | 1 | Pulse when the last READ command of a burst is issued |
| cas_lat | input | CL_W | CAS latency in cycles (2 or 3) |
| rd_cmds | input | CNT_W | Number of READ commands in the burst |
| pair_valid | input | 1 | A data pair is present at the capture path |
| cap_en | output | 1 | Capture window open |
| cs_release | output | 1 | One-cycle pulse: negate chip select, transaction done |
| busy | output | 1 | Transaction in progress |
| timeout | output | 1 | Sticky flag: ceiling reached with pairs missing |

## Verification
Every cycle, the assertions check that the window opens exactly the latched latency after the start, that it is never open beyond one cycle past latency after the last READ, that the final pair is always followed by a release pulse with the window closed, that the pair count never underflows, and that the timeout flag never clears on its own. Only the bench scenarios can show the full timing of a whole transaction. These include on-time, one-cycle-late and too-late data, missing pairs, stray pairs before the window, a repeated start pulse, back-to-back transactions beginning in the release cycle, and a reset in the middle of a burst.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OPEN = 2'd2
  } rdw_state_e;
endpackage

// File: rtl/rdw_open_delay.sv
module rdw_open_delay #(
  parameter int CL_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CL_W-1:0] cl,
  output logic            hit
);
  logic [CL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= cl - CL_W'(1);
    else if (cnt != '0) cnt <= cnt - CL_W'(1);
  end

  assign hit = (cnt == CL_W'(1));

  // R3: the open strobe lasts a single cycle per start
  assert_delay_once_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && !start) |=> !hit);
endmodule

// File: rtl/rdw_pair_counter.sv
module rdw_pair_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)         left <= '0;
    else if (load)   left <= load_val;
    else if (dec)    left <= left - CNT_W'(1);
  end

  assign last = (left == CNT_W'(1));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    dec |-> (left != '0));
endmodule

// File: rtl/rdw_ceiling_timer.sv
module rdw_ceiling_timer #(
  parameter int CL_W  = 2,
  localparam int TMR_W = CL_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm,
  input  logic            clear,
  input  logic [CL_W-1:0] cl,
  output logic            hit
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)                cnt <= '0;
    else if (arm && cnt == '0)       cnt <= TMR_W'(cl) + TMR_W'(1);
    else if (cnt > TMR_W'(1))        cnt <= cnt - TMR_W'(1);
  end

  assign hit = (cnt == TMR_W'(1));

  // R6: once expired the timer holds until the controller clears it
  assert_hold_expired_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && !clear) |=> hit);
endmodule

// File: rtl/rdw_capture_ctrl.sv
module rdw_capture_ctrl
  import rdw_pkg::*;
#(
  parameter int CL_W  = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_first,
  input  logic             rd_last,
  input  logic [CL_W-1:0]  cas_lat,
  input  logic [CNT_W-1:0] rd_cmds,
  input  logic             pair_valid,
  output logic             cap_en,
  output logic             cs_release,
  output logic             busy,
  output logic             timeout
);
  localparam int AGE_W = CL_W + 2;

  rdw_state_e      state, state_nx;
  logic [CL_W-1:0] cl_q, cl_eff;
  logic            start, arm, accept, fin_ok, fin_to, done;
  logic            open_hit, ceil_hit, pair_last;
  logic            rel_q, to_q;

  assign start  = rd_first && (state == ST_IDLE);
  assign cl_eff = start ? cas_lat : cl_q;
  assign arm    = rd_last && (start || state != ST_IDLE);
  assign accept = pair_valid && (state == ST_OPEN);
  assign fin_ok = accept && pair_last;
  assign fin_to = (state == ST_OPEN) && ceil_hit && !fin_ok;
  assign done   = fin_ok || fin_to;

  rdw_open_delay #(.CL_W(CL_W)) u_open (
    .clk(clk), .rst(rst), .start(start), .cl(cas_lat), .hit(open_hit)
  );

  rdw_pair_counter #(.CNT_W(CNT_W)) u_pairs (
    .clk(clk), .rst(rst), .load(start), .load_val(rd_cmds),
    .dec(accept), .last(pair_last)
  );

  rdw_ceiling_timer #(.CL_W(CL_W)) u_ceil (
    .clk(clk), .rst(rst), .arm(arm), .clear(done), .cl(cl_eff),
    .hit(ceil_hit)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start)    state_nx = ST_WAIT;
      ST_WAIT: if (open_hit) state_nx = ST_OPEN;
      ST_OPEN: if (done)     state_nx = ST_IDLE;
      default:               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cl_q  <= '0;
      rel_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      state <= state_nx;
      if (start) cl_q <= cas_lat;
      rel_q <= done;
      to_q  <= to_q | fin_to;
    end
  end

  assign cap_en     = (state == ST_OPEN);
  assign busy       = (state != ST_IDLE);
  assign cs_release = rel_q;
  assign timeout    = to_q;

  // Checker counters: cycles since start and since the last READ pulse
  logic [AGE_W-1:0] since_start, since_last;
  logic             last_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_start <= '0;
      since_last  <= '0;
      last_seen   <= 1'b0;
    end else begin
      if (start) since_start <= AGE_W'(1);
      else if (busy && since_start != '1) since_start <= since_start + AGE_W'(1);
      if (arm) begin
        last_seen  <= 1'b1;
        since_last <= AGE_W'(1);
      end else if (done) begin
        last_seen  <= 1'b0;
      end else if (last_seen && since_last != '1) begin
        since_last <= since_last + AGE_W'(1);
      end
    end
  end

  assert_open_at_latency_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_en) |-> (since_start == AGE_W'(cl_q)));

  assert_window_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
    (cap_en && last_seen) |-> (since_last <= AGE_W'(cl_q) + AGE_W'(1)));

  assert_release_after_final_R5: assert property (@(posedge clk) disable iff (rst)
    (cap_en && pair_valid && pair_last) |=> (cs_release && !cap_en && !timeout || cs_release && !cap_en && $past(timeout)));

  assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    timeout |=> timeout);

  assert_latency_range_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> (cas_lat >= CL_W'(2)));
endmodule

// File: tb/rdw_capture_ctrl_test.sv
module rdw_capture_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_first = 1'b0, rd_last = 1'b0, pair_valid = 1'b0;
  logic [1:0] cas_lat = 2'd2;
  logic [3:0] rd_cmds = 4'd1;
  logic       cap_en, cs_release, busy, timeout;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rdw_capture_ctrl uut (
    .clk(clk), .rst(rst), .rd_first(rd_first), .rd_last(rd_last),
    .cas_lat(cas_lat), .rd_cmds(rd_cmds), .pair_valid(pair_valid),
    .cap_en(cap_en), .cs_release(cs_release), .busy(busy), .timeout(timeout)
  );

  task automatic chk(input string req, input string sig, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; rd_first = 0; rd_last = 0; pair_valid = 0;
    @(negedge clk); @(negedge clk);
    chk("R1", "cap_en", cap_en, 1'b0);
    chk("R1", "timeout", timeout, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "cs_release", cs_release, 1'b0);
    chk("R1", "busy", busy, 1'b0);
  endtask

  // One transaction: n READs back to back, data d cycles late, drop pairs missing.
  task automatic run(input int cl, input int n, input int d, input int drop,
                     input bit early, input bit extra_first, input bit chain,
                     input bit prior_to, input bit short_end);
    bit pass;
    int end_c, last_c;
    string tag;
    pass   = (drop == 0) && (d <= 1);
    end_c  = pass ? (cl + d + n) : (n + cl + 1);
    last_c = short_end ? end_c - 1 : end_c + 2;
    if (early)            tag = "R4";
    else if (extra_first) tag = "R8";
    else if (prior_to)    tag = "R7";
    else if (d == 1)      tag = "R9";
    else if (!pass)       tag = "R6";
    else if (chain)       tag = "R5";
    else if (n == 1)      tag = "R10";
    else                  tag = "R3";
    if (!chain) do_reset();
    for (int c = 0; c <= last_c; c++) begin
      if (!(chain && c == 0)) begin
        chk(tag, "cap_en", cap_en, (c >= cl && c < end_c));
        chk("R5", "cs_release", cs_release, (c == end_c));
        chk("R2", "busy", busy, (c >= 1 && c < end_c));
        chk(pass ? tag : "R6", "timeout", timeout,
            prior_to || (!pass && c >= end_c));
      end
      rd_first   = (c == 0) || (extra_first && c == 1);
      rd_last    = (c == n - 1);
      rd_cmds    = (c == 0) ? 4'(n) : 4'd7;
      cas_lat    = (c == 0) ? 2'(cl) : ((cl == 2) ? 2'd3 : 2'd2);
      pair_valid = (c >= cl + d && c < cl + d + n - drop) || (early && c == cl - 1);
      @(negedge clk);
    end
    rd_first = 0; rd_last = 0; pair_valid = 0;
  endtask

  initial begin
    for (int cl = 2; cl <= 3; cl++)
      for (int n = 1; n <= 4; n++) begin
        run(cl, n, 0, 0, 0, 0, 0, 0, 0);
        run(cl, n, 1, 0, 0, 0, 0, 0, 0);
        run(cl, n, 2, 0, 0, 0, 0, 0, 0);
        run(cl, n, 0, 1, 0, 0, 0, 0, 0);
        run(cl, n, 0, n, 0, 0, 0, 0, 0);
        run(cl, n, 0, 0, 1, 0, 0, 0, 0);
        run(cl, n, 0, 0, 0, 1, 0, 0, 0);
        // back to back: second start lands in the release cycle
        run(cl, n, 0, 0, 0, 0, 0, 0, 1);
        run(cl, n, 0, 0, 0, 0, 1, 0, 0);
        // timeout stays set through a later good transaction
        run(cl, n, 0, 1, 0, 0, 0, 0, 0);
        run(cl, 2, 0, 0, 0, 0, 1, 1, 0);
      end
    // R1: reset in the middle of an open window after a timeout
    run(2, 3, 0, 3, 0, 0, 0, 0, 0);
    rd_first = 1; rd_cmds = 4'd4; cas_lat = 2'd2;
    @(negedge clk);
    rd_first = 0;
    @(negedge clk); @(negedge clk);
    chk("R1", "cap_en_open", cap_en, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "cap_en", cap_en, 1'b0);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "timeout", timeout, 1'b0);
    chk("R1", "cs_release", cs_release, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule